// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Condition-Code Register

This block is the arithmetic and logic datapath of a small 8-bit processor that also works on pairs of bytes as 16-bit accumulators. Each cycle it takes an operation code, a width select and two operands. It produces a result and the next value of the condition-code byte. The condition-code byte is held in an internal register. The same register supplies the carry input and the flags that are kept unchanged.

The supported operations are: add, add-with-carry, bitwise AND, an unsigned index add (an 8-bit offset added to a 16-bit base), and AND or OR masking of the condition-code byte itself. Flag behaviour depends on the operation and on the width. The half-carry flag comes only from 8-bit adds. Logic operations clear overflow and keep carry. The index add leaves every flag alone. The register loads the next condition-code value on a clock edge only when the update enable is high.

Top module: `cc_alu`

## Requirements
- R1: The condition-code byte has flag E at bit 7, F at bit 6, H at bit 5, I at bit 4, N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. With op_i = 0 (add) and wide_i = 0, the low bytes are summed, and the flags are set as follows:
  - H is the carry into bit 4.
  - N is result bit 7.
  - Z is set when the 8-bit result is zero.
  - V is signed overflow.
  - C is the carry out of bit 7.
  - E, F and I keep their values.
- R2: With wide_i = 1, add and add-with-carry work on all 16 bits, and the flags are set as follows:
  - N is result bit 15.
  - Z is set when the 16-bit result is zero.
  - V is signed overflow at bit 15.
  - C is the carry out of bit 15.
  - H, E, F and I keep their values.
- R3: op_i = 1 (add-with-carry) adds the current C flag to the operand sum, at either width. The flags follow R1 or R2.
- R4: op_i = 2 (AND) gives the bitwise AND at the selected width. N and Z come from the result, V is cleared, and C, H, E, F and I keep their values.
- R5: op_i = 3 (index add) returns opa_i plus the zero-extended low byte of opb_i as a 16-bit sum. The upper byte of opb_i and wide_i have no effect, and every flag keeps its value.
- R6: op_i = 4 clears each condition-code bit whose bit in the opb_i[7:0] mask is 0 and keeps the others. result_o is the new condition-code byte, zero-extended.
- R7: op_i = 5 sets each condition-code bit whose bit in the opb_i[7:0] mask is 1 and keeps the others. result_o is the new condition-code byte, zero-extended.
- R8: For 8-bit add, add-with-carry and AND, result_o[15:8] is zero, and the upper bytes of the operands do not affect the result or the flags.
- R9: On reset, cc_o becomes 0x50 (F and I set). At a clock edge, cc_o takes the value of cc_next_o when upd_i is 1, and holds its value when upd_i is 0.
- R10: op_i = 6 and op_i = 7 give a result of zero and leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| wide_i | input | 1 | 1 selects 16-bit width, 0 selects 8-bit |
| opa_i | input | 16 | First operand (accumulator or base) |
| opb_i | input | 16 | Second operand, offset or mask |
| upd_i | input | 1 | Condition-code register write enable |
| result_o | output | 16 | Operation result |
| cc_next_o | output | 8 | Condition-code value to be written |
| cc_o | output | 8 | Registered condition-code byte |

## Verification
The checker treats op_i, wide_i and upd_i as valid two-state values during each clock cycle. It judges flags relative to the registered cc_o, so it assumes that no other agent writes the register. The bench drives every input on the falling edge. It sets the incoming condition codes only through the block's own mask operations. Because of this, every precondition the checker relies on is produced by the block's normal interface, with its inputs held steady across each rising edge.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
  localparam int DW  = 16;
  localparam int BW  = 8;
  localparam int CCW = 8;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_ADC   = 3'd1,
    OP_AND   = 3'd2,
    OP_IDX   = 3'd3,
    OP_CCAND = 3'd4,
    OP_CCOR  = 3'd5
  } alu_op_e;

  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_N = 3;
  localparam int FLG_H = 5;

  localparam logic [CCW-1:0] CC_RESET = 8'h50;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          wide_i,
  output logic [DW-1:0] sum_o,
  output logic          h_o,
  output logic          n_o,
  output logic          z_o,
  output logic          v_o,
  output logic          c_o
);
  localparam int NW = BW / 2;

  logic [BW:0] s_byte;
  logic [DW:0] s_word;
  logic [NW:0] s_nib;

  always_comb begin
    s_byte = {1'b0, a_i[BW-1:0]} + {1'b0, b_i[BW-1:0]} + {{BW{1'b0}}, cin_i};
    s_word = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
    s_nib  = {1'b0, a_i[NW-1:0]} + {1'b0, b_i[NW-1:0]} + {{NW{1'b0}}, cin_i};
    h_o    = s_nib[NW];
    if (wide_i) begin
      sum_o = s_word[DW-1:0];
      n_o   = s_word[DW-1];
      z_o   = (s_word[DW-1:0] == '0);
      c_o   = s_word[DW];
      v_o   = (a_i[DW-1] == b_i[DW-1]) && (s_word[DW-1] != a_i[DW-1]);
    end else begin
      sum_o = {{(DW-BW){1'b0}}, s_byte[BW-1:0]};
      n_o   = s_byte[BW-1];
      z_o   = (s_byte[BW-1:0] == '0);
      c_o   = s_byte[BW];
      v_o   = (a_i[BW-1] == b_i[BW-1]) && (s_byte[BW-1] != a_i[BW-1]);
    end
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          wide_i,
  output logic [DW-1:0] res_o,
  output logic          n_o,
  output logic          z_o
);
  logic [DW-1:0] conj;

  always_comb begin
    conj = a_i & b_i;
    if (wide_i) begin
      res_o = conj;
      n_o   = conj[DW-1];
    end else begin
      res_o = {{(DW-BW){1'b0}}, conj[BW-1:0]};
      n_o   = conj[BW-1];
    end
    z_o = (res_o == '0);
  end
endmodule

// File: rtl/cc_reg.sv
module cc_reg #(
  parameter int             CCW   = 8,
  parameter logic [CCW-1:0] RST_V = '0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [CCW-1:0] d_i,
  output logic [CCW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_V;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_alu_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2:0]     op_i,
  input  logic           wide_i,
  input  logic [DW-1:0]  opa_i,
  input  logic [DW-1:0]  opb_i,
  input  logic           upd_i,
  output logic [DW-1:0]  result_o,
  output logic [CCW-1:0] cc_next_o,
  output logic [CCW-1:0] cc_o
);
  logic [DW-1:0] add_sum, and_res, idx_sum;
  logic add_h, add_n, add_z, add_v, add_c;
  logic and_n, and_z;
  logic add_cin;

  // ADC takes the registered carry; plain ADD forces zero
  assign add_cin = (op_i == OP_ADC) ? cc_o[FLG_C] : 1'b0;
  assign idx_sum = opa_i + {{(DW-BW){1'b0}}, opb_i[BW-1:0]};

  alu_adder #(.DW(DW), .BW(BW)) i_adder (
    .a_i(opa_i), .b_i(opb_i), .cin_i(add_cin), .wide_i(wide_i),
    .sum_o(add_sum), .h_o(add_h), .n_o(add_n), .z_o(add_z),
    .v_o(add_v), .c_o(add_c)
  );

  alu_logic #(.DW(DW), .BW(BW)) i_logic (
    .a_i(opa_i), .b_i(opb_i), .wide_i(wide_i),
    .res_o(and_res), .n_o(and_n), .z_o(and_z)
  );

  always_comb begin
    cc_next_o = cc_o;
    result_o  = '0;
    case (op_i)
      OP_ADD, OP_ADC: begin
        result_o         = add_sum;
        cc_next_o[FLG_N] = add_n;
        cc_next_o[FLG_Z] = add_z;
        cc_next_o[FLG_V] = add_v;
        cc_next_o[FLG_C] = add_c;
        if (!wide_i) cc_next_o[FLG_H] = add_h;
      end
      OP_AND: begin
        result_o         = and_res;
        cc_next_o[FLG_N] = and_n;
        cc_next_o[FLG_Z] = and_z;
        cc_next_o[FLG_V] = 1'b0;
      end
      OP_IDX: result_o = idx_sum;
      OP_CCAND: begin
        cc_next_o = cc_o & opb_i[CCW-1:0];
        result_o  = {{(DW-CCW){1'b0}}, cc_next_o};
      end
      OP_CCOR: begin
        cc_next_o = cc_o | opb_i[CCW-1:0];
        result_o  = {{(DW-CCW){1'b0}}, cc_next_o};
      end
      default: ;
    endcase
  end

  cc_reg #(.CCW(CCW), .RST_V(CC_RESET)) i_cc_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(upd_i),
    .d_i(cc_next_o), .q_o(cc_o)
  );
endmodule

// File: rtl/cc_alu_chk.sv
module cc_alu_chk
  import cc_alu_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic [2:0]     op_i,
  input logic           wide_i,
  input logic [DW-1:0]  opa_i,
  input logic [DW-1:0]  opb_i,
  input logic           upd_i,
  input logic [DW-1:0]  result_o,
  input logic [CCW-1:0] cc_next_o,
  input logic [CCW-1:0] cc_o
);
  // R9
  cc_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> cc_o == $past(cc_next_o));

  // R9
  cc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(cc_o));

  // R5
  idx_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_IDX) |-> (cc_next_o == cc_o &&
      result_o == opa_i + {8'h00, opb_i[BW-1:0]}));

  // R4
  and_vc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_AND) |-> (!cc_next_o[FLG_V] && cc_next_o[FLG_C] == cc_o[FLG_C]
      && cc_next_o[FLG_H] == cc_o[FLG_H]));

  // R2
  wide_h_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == OP_ADD || op_i == OP_ADC) && wide_i) |-> cc_next_o[FLG_H] == cc_o[FLG_H]);

  // R8
  byte_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == OP_ADD || op_i == OP_ADC || op_i == OP_AND) && !wide_i)
      |-> result_o[DW-1:BW] == '0);

  // R10
  unused_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 3'd5) |-> (result_o == '0 && cc_next_o == cc_o));

  // R1
  keep_efi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i < 3'd4) |-> cc_next_o[7:6] == cc_o[7:6] && cc_next_o[4] == cc_o[4]);
endmodule

bind cc_alu cc_alu_chk i_chk (.*);

// File: tb/test_cc_alu.sv
module test_cc_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = '0;
  logic        wide_i = 1'b0;
  logic [15:0] opa_i = '0;
  logic [15:0] opb_i = '0;
  logic        upd_i = 1'b0;
  logic [15:0] result_o;
  logic [7:0]  cc_next_o;
  logic [7:0]  cc_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  cc_alu i_cc_alu (.*);

  // {op, wide, a, b, cc_in, exp_result, exp_cc}
  localparam int NV = 19;
  localparam logic [67:0] VECS [NV] = '{
    {3'd0, 1'b0, 16'h000F, 16'h0001, 8'h00, 16'h0010, 8'h20}, // R1 half carry
    {3'd0, 1'b0, 16'h007F, 16'h0001, 8'h00, 16'h0080, 8'h2A}, // R1 overflow
    {3'd0, 1'b0, 16'h00FF, 16'h0001, 8'h00, 16'h0000, 8'h25}, // R1 zero/carry
    {3'd1, 1'b0, 16'h0010, 16'h0020, 8'h01, 16'h0031, 8'h00}, // R3
    {3'd1, 1'b0, 16'h0080, 16'h007F, 8'hD1, 16'h0000, 8'hF5}, // R3 R1 keep EFI
    {3'd0, 1'b1, 16'h7FFF, 16'h0001, 8'h20, 16'h8000, 8'h2A}, // R2 H kept
    {3'd0, 1'b1, 16'hFFFF, 16'h0001, 8'h00, 16'h0000, 8'h05}, // R2 no H
    {3'd1, 1'b1, 16'h1234, 16'h1111, 8'h01, 16'h2346, 8'h00}, // R3 wide
    {3'd1, 1'b1, 16'h8000, 16'h8000, 8'h00, 16'h0000, 8'h07}, // R2 V
    {3'd2, 1'b0, 16'h00F0, 16'h008F, 8'h23, 16'h0080, 8'h29}, // R4
    {3'd2, 1'b0, 16'h000F, 16'h00F0, 8'h02, 16'h0000, 8'h04}, // R4 zero
    {3'd2, 1'b1, 16'hE123, 16'hE000, 8'h01, 16'hE000, 8'h09}, // R4 wide
    {3'd3, 1'b0, 16'h301B, 16'h00FF, 8'hAA, 16'h311A, 8'hAA}, // R5
    {3'd3, 1'b1, 16'hFFFF, 16'hAB01, 8'h05, 16'h0000, 8'h05}, // R5 wrap
    {3'd4, 1'b0, 16'h0000, 16'h00AF, 8'hFF, 16'h00AF, 8'hAF}, // R6
    {3'd4, 1'b1, 16'h1234, 16'h00FE, 8'h55, 16'h0054, 8'h54}, // R6
    {3'd5, 1'b0, 16'h0000, 16'h0050, 8'h01, 16'h0051, 8'h51}, // R7
    {3'd0, 1'b0, 16'hAB01, 16'hCD02, 8'h00, 16'h0003, 8'h00}, // R8
    {3'd6, 1'b1, 16'h1111, 16'h2222, 8'h33, 16'h0000, 8'h33}  // R10
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic wide, input logic [15:0] a,
                      input logic [15:0] b, input logic upd);
    @(negedge clk_i);
    op_i = op; wide_i = wide; opa_i = a; opb_i = b; upd_i = upd;
    #1;
  endtask

  task automatic finish_clock();
    @(negedge clk_i);
    upd_i = 1'b0;
  endtask

  task automatic load_cc(input logic [7:0] v);
    step(3'd4, 1'b0, 16'h0, 16'h0000, 1'b1);
    step(3'd5, 1'b0, 16'h0, {8'h00, v}, 1'b1);
    finish_clock();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check("R9 reset cc", {8'h00, cc_o}, 16'h0050);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [67:0] v;
      v = VECS[i];
      load_cc(v[31:24]);
      check($sformatf("R6 R7 cc preload %0d", i), {8'h00, cc_o}, {8'h00, v[31:24]});
      step(v[67:65], v[64], v[63:48], v[47:32], 1'b1);
      check($sformatf("vector %0d result", i), result_o, v[23:8]);
      check($sformatf("vector %0d cc_next", i), {8'h00, cc_next_o}, {8'h00, v[7:0]});
      finish_clock();
      check($sformatf("R9 vector %0d cc_o", i), {8'h00, cc_o}, {8'h00, v[7:0]});
    end

    // R9: no load without enable
    load_cc(8'h00);
    step(3'd0, 1'b0, 16'h00FF, 16'h0001, 1'b0);
    check("R9 next visible", {8'h00, cc_next_o}, 16'h0025);
    finish_clock();
    check("R9 hold", {8'h00, cc_o}, 16'h0000);

    // R3: carry chain 0x01FF + 0x0001 done as two byte ops
    load_cc(8'h00);
    step(3'd0, 1'b0, 16'h00FF, 16'h0001, 1'b1);
    finish_clock();
    step(3'd1, 1'b0, 16'h0001, 16'h0000, 1'b1);
    check("R3 carry chain", result_o, 16'h0002);
    finish_clock();
    check("R3 carry chain flags", {8'h00, cc_o}, 16'h0000);

    // R9: reset mid-run returns to 0x50
    load_cc(8'hFF);
    rst_ni = 1'b0;
    #1;
    check("R9 async reset", {8'h00, cc_o}, 16'h0050);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule